// File: doc/BRIEF.md
# Configurable Serial Transceiver

This block is a full-duplex asynchronous serial port: a transmitter and a receiver that share one 8-bit control register and one baud tick generator. The transmitter takes a character through a load strobe into a one-deep holding buffer. It frames the character with a start bit and a stop bit and shifts it out least significant bit first on `txd_o`. The receiver oversamples its serial input 16 times per bit. It checks the start bit at its middle and the stop bit at its end, and it presents each good character with a one-cycle valid pulse.

The control register selects several modes. An internal loopback routes the transmitter's serial level straight into the receiver, so the external pin plays no part. Output polarity inversion covers every transmitted level, including the idle line. The character can carry 8 or 9 data bits. Even or odd parity can take the place of the top data bit. Clearing the enable bit stops the baud generator, clears both engines and forces the transmitter's status flags to their set state. Two further control bits, a wakeup method select and an idle type select, are stored and read back but do not affect the serial lines.

Top module: `serial_xcvr`

## Requirements
- R1: After reset the control register reads 0x00, `txd_o` is 1, `tx_empty_o` and `tx_done_o` are 1, and `tx_irq_o` and `rx_valid_o` are 0.
- R2: When control bit 7 (loopback) is 1, the receiver takes the transmitter's serial level before inversion, and activity on `rxd_i` produces no received character.
- R3: When control bit 6 (enable) is 0, the baud generator and both engines are held cleared, `tx_empty_o` and `tx_done_o` read 1 and `tx_irq_o` reads 0 in the same cycle, and a `tx_load_i` pulse is ignored.
- R4: When control bit 5 (invert) is 1, every level on `txd_o` is inverted, including the idle level. The idle line is therefore 0.
- R5: A frame is a low start bit, the data bits least significant first, and a high stop bit. Each bit lasts 16 baud ticks of BAUD_DIV clocks each. Control bit 4 = 0 selects 8 data bits.
- R6: Control bit 4 = 1 selects 9 data bits in both directions. `rx_data_o[8]` carries the ninth bit, and it reads 0 in 8-bit mode.
- R7: When control bit 1 (parity enable) is 1, the top data position (bit 7, or bit 8 in 9-bit mode) is replaced by a parity bit over the bits below it. Control bit 0 = 0 makes the count of ones across the data field even, and 1 makes it odd.
- R8: A load is accepted only while `tx_empty_o` is 1, and a load while the buffer is full is ignored. A frame starts on a baud tick. A buffered character follows the previous stop bit with no idle gap.
- R9: `tx_done_o` falls after an accepted load and rises when a stop bit ends with nothing buffered. `tx_irq_o` equals enable AND `tx_empty_o`.
- R10: A low level on the receiver input that is gone by the 8th tick after it is detected is discarded and yields no character.
- R11: A character is delivered with a one-cycle `rx_valid_o` pulse only if its stop bit samples high. `rx_data_o` holds its value between pulses.
- R12: Control bits 3 and 2 are stored and read back but have no effect on `txd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register read data |
| tx_data_i | input | 9 | Character to transmit |
| tx_load_i | input | 1 | Load strobe for `tx_data_i` |
| rx_data_o | output | 9 | Last received character |
| rx_valid_o | output | 1 | One-cycle pulse when a character arrives |
| rxd_i | input | 1 | Serial receive pin |
| txd_o | output | 1 | Serial transmit pin |
| tx_empty_o | output | 1 | Holding buffer can take a character |
| tx_done_o | output | 1 | Transmitter fully idle |
| tx_irq_o | output | 1 | Transmit request interrupt |

## Verification
The assertions assume three things. The character length bit is not rewritten while a character is being received. `tx_load_i` is the only way the holding buffer fills. Reset is held for several clocks before release. The stimulus changes control bits only while both directions are idle or deliberately disabled, with one exception: the mid-frame disable case, which needs the enable bit cleared during a frame. Externally driven frames use exactly 16·BAUD_DIV clocks per bit, and the line returns high between them. The glitch and bad-stop cases are timed so that the receiver's mid-bit sample falls well inside the intended level.

// File: rtl/serial_xcvr_pkg.sv
package serial_xcvr_pkg;

  localparam int unsigned DATA_W  = 9;
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned IDX_W   = 4;

  typedef struct packed {
    logic loop_en;
    logic xcvr_en;
    logic tx_inv;
    logic mode9;
    logic wake_sel;
    logic idle_sel;
    logic par_en;
    logic par_odd;
  } ctrl_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

endpackage

// File: rtl/serial_baud_gen.sv
module serial_baud_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);

  localparam int unsigned CntW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CntW-1:0] CntMax = CntW'(DIV - 1);

  logic [CntW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CntMax);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CntW'(1);
    end
  end

endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
  import serial_xcvr_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              mode9_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              line_o,
  output logic              empty_o,
  output logic              done_o
);

  localparam int unsigned SubW = $clog2(OSR);
  localparam logic [SubW-1:0] SubMax = SubW'(OSR - 1);
  localparam logic [IDX_W-1:0] Last9 = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] Last8 = IDX_W'(FRAME_W - 2);

  logic [DATA_W-1:0]  hold_q;
  logic               hold_full_q;
  logic               busy_q;
  logic [FRAME_W-1:0] shift_q;
  logic [FRAME_W-1:0] frame_d;
  logic [DATA_W-1:0]  fld;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   last_q;
  logic [IDX_W-1:0]   last_d;
  logic [SubW-1:0]    sub_q;
  logic               bit_end;
  logic               last_bit;
  logic               start_go;

  // parity replaces the top data slot of the selected length
  always_comb begin
    fld = hold_q;
    if (mode9_i) begin
      if (par_en_i) fld[8] = par_odd_i ^ (^hold_q[7:0]);
      frame_d = {1'b1, fld, 1'b0};
      last_d  = Last9;
    end else begin
      if (par_en_i) fld[7] = par_odd_i ^ (^hold_q[6:0]);
      frame_d = {2'b11, fld[7:0], 1'b0};
      last_d  = Last8;
    end
  end

  assign bit_end  = busy_q && tick_i && (sub_q == SubMax);
  assign last_bit = (idx_q == last_q);
  assign start_go = tick_i && hold_full_q && (!busy_q || (bit_end && last_bit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      busy_q      <= 1'b0;
      shift_q     <= '1;
      idx_q       <= '0;
      last_q      <= '0;
      sub_q       <= '0;
    end else if (!en_i) begin
      hold_full_q <= 1'b0;
      busy_q      <= 1'b0;
      shift_q     <= '1;
      idx_q       <= '0;
      sub_q       <= '0;
    end else begin
      if (load_i && !hold_full_q) begin
        hold_q      <= data_i;
        hold_full_q <= 1'b1;
      end
      if (start_go) begin
        shift_q     <= frame_d;
        last_q      <= last_d;
        busy_q      <= 1'b1;
        idx_q       <= '0;
        sub_q       <= '0;
        hold_full_q <= 1'b0;
      end else if (busy_q && tick_i) begin
        if (sub_q == SubMax) begin
          sub_q <= '0;
          if (last_bit) begin
            busy_q <= 1'b0;
          end else begin
            shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
            idx_q   <= idx_q + IDX_W'(1);
          end
        end else begin
          sub_q <= sub_q + SubW'(1);
        end
      end
    end
  end

  assign line_o  = busy_q ? shift_q[0] : 1'b1;
  assign empty_o = !hold_full_q;
  assign done_o  = !busy_q && !hold_full_q;

endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import serial_xcvr_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              mode9_i,
  input  logic              line_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);

  localparam int unsigned SubW = $clog2(OSR);
  localparam logic [SubW-1:0] SubMax  = SubW'(OSR - 1);
  localparam logic [SubW-1:0] HalfMax = SubW'(OSR / 2 - 1);
  localparam logic [IDX_W-1:0] Top9 = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] Top8 = IDX_W'(DATA_W - 2);

  rx_state_e         state_q;
  logic [SubW-1:0]   sub_q;
  logic [IDX_W-1:0]  bit_q;
  logic [DATA_W-1:0] shift_q;
  logic [DATA_W-1:0] data_q;
  logic              m9_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      sub_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      data_q  <= '0;
      m9_q    <= 1'b0;
      valid_q <= 1'b0;
    end else if (!en_i) begin
      state_q <= RX_IDLE;
      sub_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (tick_i) begin
        case (state_q)
          RX_IDLE: begin
            if (!line_i) begin
              state_q <= RX_START;
              sub_q   <= '0;
              m9_q    <= mode9_i;
            end
          end
          RX_START: begin
            // start must still be low at its middle
            if (sub_q == HalfMax) begin
              sub_q   <= '0;
              bit_q   <= '0;
              state_q <= line_i ? RX_IDLE : RX_DATA;
            end else begin
              sub_q <= sub_q + SubW'(1);
            end
          end
          RX_DATA: begin
            if (sub_q == SubMax) begin
              sub_q   <= '0;
              shift_q <= {line_i, shift_q[DATA_W-1:1]};
              if (bit_q == (m9_q ? Top9 : Top8)) state_q <= RX_STOP;
              else bit_q <= bit_q + IDX_W'(1);
            end else begin
              sub_q <= sub_q + SubW'(1);
            end
          end
          RX_STOP: begin
            if (sub_q == SubMax) begin
              sub_q   <= '0;
              state_q <= RX_IDLE;
              if (line_i) begin
                valid_q <= 1'b1;
                data_q  <= m9_q ? shift_q : {1'b0, shift_q[DATA_W-1:1]};
              end
            end else begin
              sub_q <= sub_q + SubW'(1);
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
  import serial_xcvr_pkg::*;
#(
  parameter int unsigned BAUD_DIV    = 4,
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_we_i,
  input  logic [7:0] ctl_wdata_i,
  output logic [7:0] ctl_rdata_o,
  input  logic [8:0] tx_data_i,
  input  logic       tx_load_i,
  output logic [8:0] rx_data_o,
  output logic       rx_valid_o,
  input  logic       rxd_i,
  output logic       txd_o,
  output logic       tx_empty_o,
  output logic       tx_done_o,
  output logic       tx_irq_o
);

  ctrl_t ctrl_q;
  logic  tick;
  logic  eng_line;
  logic  eng_empty;
  logic  eng_done;
  logic  tx_line;
  logic  rx_line;
  logic  pin_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (ctl_we_i) ctrl_q <= ctrl_t'(ctl_wdata_i);
  end

  assign ctl_rdata_o = ctrl_q;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= 1'b1;
        else s_q <= rxd_i;
      end
      assign pin_sync = s_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '1;
        else s_q <= {s_q[SYNC_STAGES-2:0], rxd_i};
      end
      assign pin_sync = s_q[SYNC_STAGES-1];
    end
  endgenerate

  serial_baud_gen #(.DIV(BAUD_DIV)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl_q.xcvr_en),
    .tick_o (tick)
  );

  serial_tx_engine #(.OSR(OSR)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (ctrl_q.xcvr_en),
    .tick_i    (tick),
    .mode9_i   (ctrl_q.mode9),
    .par_en_i  (ctrl_q.par_en),
    .par_odd_i (ctrl_q.par_odd),
    .load_i    (tx_load_i),
    .data_i    (tx_data_i),
    .line_o    (eng_line),
    .empty_o   (eng_empty),
    .done_o    (eng_done)
  );

  // disabled: idle level immediately, flags forced set
  assign tx_line    = ctrl_q.xcvr_en ? eng_line : 1'b1;
  assign txd_o      = tx_line ^ ctrl_q.tx_inv;
  assign rx_line    = ctrl_q.loop_en ? tx_line : pin_sync;
  assign tx_empty_o = !ctrl_q.xcvr_en || eng_empty;
  assign tx_done_o  = !ctrl_q.xcvr_en || eng_done;
  assign tx_irq_o   = ctrl_q.xcvr_en && eng_empty;

  serial_rx_engine #(.OSR(OSR)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl_q.xcvr_en),
    .tick_i  (tick),
    .mode9_i (ctrl_q.mode9),
    .line_i  (rx_line),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o)
  );

endmodule

// File: rtl/serial_xcvr_chk.sv
module serial_xcvr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] ctl_rdata_o,
  input logic       tx_load_i,
  input logic       txd_o,
  input logic       tx_empty_o,
  input logic       tx_done_o,
  input logic       tx_irq_o,
  input logic [8:0] rx_data_o,
  input logic       rx_valid_o
);

  assert_disable_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_rdata_o[6] |-> (tx_empty_o && tx_done_o && !tx_irq_o));

  assert_idle_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> (txd_o == !ctl_rdata_o[5]));

  assert_fill_by_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_empty_o) |-> $past(tx_load_i));

  assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_o && !tx_load_i && ctl_rdata_o[6]) |=> tx_done_o);

  assert_irq_follows_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> (tx_empty_o && ctl_rdata_o[6]));

  assert_valid_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_data_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |=> (rx_valid_o || $stable(rx_data_o)));

  assert_ninth_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !$past(ctl_rdata_o[4])) |-> !rx_data_o[8]);

endmodule

bind serial_xcvr serial_xcvr_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_rdata_o (ctl_rdata_o),
  .tx_load_i   (tx_load_i),
  .txd_o       (txd_o),
  .tx_empty_o  (tx_empty_o),
  .tx_done_o   (tx_done_o),
  .tx_irq_o    (tx_irq_o),
  .rx_data_o   (rx_data_o),
  .rx_valid_o  (rx_valid_o)
);

// File: tb/serial_xcvr_tb_top.sv
`timescale 1ns / 1ps
module serial_xcvr_tb_top;

  localparam int DIV  = 4;
  localparam int BIT  = 16 * DIV;
  localparam int FRM  = 11 * BIT;
  localparam int WDOG = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctl_we_i = 1'b0;
  logic [7:0] ctl_wdata_i = 8'h00;
  logic [7:0] ctl_rdata_o;
  logic [8:0] tx_data_i = 9'h000;
  logic       tx_load_i = 1'b0;
  logic [8:0] rx_data_o;
  logic       rx_valid_o;
  logic       rxd_i = 1'b1;
  logic       txd_o;
  logic       tx_empty_o;
  logic       tx_done_o;
  logic       tx_irq_o;

  always #4 clk_i = ~clk_i;

  serial_xcvr #(.BAUD_DIV(DIV)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_we_i    (ctl_we_i),
    .ctl_wdata_i (ctl_wdata_i),
    .ctl_rdata_o (ctl_rdata_o),
    .tx_data_i   (tx_data_i),
    .tx_load_i   (tx_load_i),
    .rx_data_o   (rx_data_o),
    .rx_valid_o  (rx_valid_o),
    .rxd_i       (rxd_i),
    .txd_o       (txd_o),
    .tx_empty_o  (tx_empty_o),
    .tx_done_o   (tx_done_o),
    .tx_irq_o    (tx_irq_o)
  );

  int checks = 0;
  int fails  = 0;
  int rx_seen = 0;
  bit cmp_en = 1'b0;
  bit done_run = 1'b0;

  logic [8:0] rx_exp_q[$];
  string      rx_tag_q[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h @%0t", req, what, act, exp, $time);
    end
  endtask

  // character as it appears on the line / at the receiver
  function automatic logic [8:0] shaped(input logic [8:0] d, input bit m9, input bit pe, input bit po);
    logic [8:0] r;
    r = m9 ? d : {1'b0, d[7:0]};
    if (pe) begin
      if (m9) r[8] = po ^ (^d[7:0]);
      else    r[7] = po ^ (^d[6:0]);
    end
    return r;
  endfunction

  // reference model
  logic [7:0]  m_ctrl;
  int          m_cnt;
  bit          m_full;
  logic [8:0]  m_hold;
  bit          m_busy;
  logic [10:0] m_bits;
  logic [3:0]  m_idx;
  logic [3:0]  m_len;
  int          m_sub;

  always @(posedge clk_i) begin
    bit en, tick, full_old, fin;
    logic [8:0] r;
    if (!rst_ni) begin
      m_ctrl = 8'h00; m_cnt = 0; m_full = 0; m_hold = '0; m_busy = 0;
      m_bits = '1; m_idx = '0; m_len = 4'd10; m_sub = 0;
    end else begin
      en = m_ctrl[6];
      tick = en && (m_cnt == DIV - 1);
      if (!en) begin
        m_cnt = 0; m_full = 0; m_busy = 0; m_idx = '0; m_sub = 0;
      end else begin
        m_cnt = tick ? 0 : m_cnt + 1;
        full_old = m_full;
        fin = m_busy && tick && (m_sub == 15) && (m_idx == m_len - 4'd1);
        if (tx_load_i && !full_old) begin
          m_hold = tx_data_i;
          m_full = 1;
        end
        if (tick && full_old && (!m_busy || fin)) begin
          r = shaped(m_hold, m_ctrl[4], m_ctrl[1], m_ctrl[0]);
          if (m_ctrl[4]) begin m_bits = {1'b1, r, 1'b0}; m_len = 4'd11; end
          else begin m_bits = {2'b11, r[7:0], 1'b0}; m_len = 4'd10; end
          m_busy = 1; m_idx = '0; m_sub = 0; m_full = 0;
        end else if (m_busy && tick) begin
          if (m_sub == 15) begin
            m_sub = 0;
            if (m_idx == m_len - 4'd1) m_busy = 0;
            else m_idx = m_idx + 4'd1;
          end else begin
            m_sub = m_sub + 1;
          end
        end
      end
      if (ctl_we_i) m_ctrl = ctl_wdata_i;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk_i) begin
    logic e_txd;
    bit en;
    if (cmp_en && rst_ni) begin
      en = m_ctrl[6];
      e_txd = ((en && m_busy) ? m_bits[m_idx] : 1'b1) ^ m_ctrl[5];
      chk(txd_o == e_txd, "R5", "txd_o", int'(txd_o), int'(e_txd));
      chk(tx_empty_o == (!en || !m_full), "R8", "tx_empty_o", int'(tx_empty_o), int'(!en || !m_full));
      chk(tx_done_o == (!en || (!m_busy && !m_full)), "R9", "tx_done_o",
          int'(tx_done_o), int'(!en || (!m_busy && !m_full)));
      chk(tx_irq_o == (en && !m_full), "R9", "tx_irq_o", int'(tx_irq_o), int'(en && !m_full));
      if (rx_valid_o) begin
        rx_seen++;
        if (rx_exp_q.size() == 0) begin
          chk(1'b0, "R11", "unexpected rx_data_o", int'(rx_data_o), 0);
        end else begin
          logic [8:0] ev;
          string tg;
          ev = rx_exp_q.pop_front();
          tg = rx_tag_q.pop_front();
          chk(rx_data_o == ev, tg, "rx_data_o", int'(rx_data_o), int'(ev));
        end
      end
    end
  end

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk_i);
    ctl_we_i = 1'b1; ctl_wdata_i = v;
    @(negedge clk_i);
    ctl_we_i = 1'b0;
  endtask

  task automatic load(input logic [8:0] d);
    @(negedge clk_i);
    tx_load_i = 1'b1; tx_data_i = d;
    @(negedge clk_i);
    tx_load_i = 1'b0;
  endtask

  task automatic expect_rx(input logic [8:0] d, input string tg);
    rx_exp_q.push_back(d);
    rx_tag_q.push_back(tg);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic hold_rx(input logic v);
    rxd_i = v;
    repeat (BIT) @(negedge clk_i);
  endtask

  task automatic drive_rx(input logic [8:0] d, input bit m9, input logic stop);
    @(negedge clk_i);
    hold_rx(1'b0);
    for (int i = 0; i < (m9 ? 9 : 8); i++) hold_rx(d[i]);
    hold_rx(stop);
    rxd_i = 1'b1;
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk_i);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    finish_run();
  end

  initial begin
    int seen0;
    // R1 reset state
    idle(3);
    chk(ctl_rdata_o == 8'h00, "R1", "ctl_rdata_o", int'(ctl_rdata_o), 0);
    chk(txd_o == 1'b1, "R1", "txd_o", int'(txd_o), 1);
    chk(tx_empty_o && tx_done_o, "R1", "flags", int'({tx_empty_o, tx_done_o}), 3);
    chk(!tx_irq_o && !rx_valid_o, "R1", "irq/valid", int'({tx_irq_o, rx_valid_o}), 0);
    rst_ni = 1'b1;
    cmp_en = 1'b1;
    idle(4);

    // R12 inert bits read back
    wr_ctl(8'h0C);
    chk(ctl_rdata_o == 8'h0C, "R12", "ctl_rdata_o", int'(ctl_rdata_o), 'h0C);
    idle(50);
    chk(txd_o == 1'b1, "R12", "txd_o", int'(txd_o), 1);

    // R5 basic 8-bit frame through loopback
    wr_ctl(8'hC0);
    load(9'h0A5); expect_rx(9'h0A5, "R5");
    idle(FRM);

    // R8 buffering: second load while full ignored, buffered char follows without gap
    load(9'h03C);
    load(9'h099);
    idle(100);
    load(9'h05A);
    idle(5);
    load(9'h077);
    expect_rx(9'h03C, "R8"); expect_rx(9'h05A, "R8");
    idle(2 * FRM + 100);

    // R4 inversion incl. idle; R2 loopback uses pre-inversion level
    wr_ctl(8'hE0);
    chk(txd_o == 1'b0, "R4", "idle txd_o", int'(txd_o), 0);
    load(9'h00F); expect_rx(9'h00F, "R2");
    idle(FRM);

    // R6 nine data bits
    wr_ctl(8'hD0);
    load(9'h1C3); expect_rx(9'h1C3, "R6");
    idle(FRM);
    load(9'h0AA); expect_rx(9'h0AA, "R6");
    idle(FRM);

    // R7 parity even/odd, both lengths
    wr_ctl(8'hC2);
    load(9'h007); expect_rx(shaped(9'h007, 0, 1, 0), "R7");
    idle(FRM);
    chk(shaped(9'h007, 0, 1, 0) == 9'h087, "R7", "even parity ref", int'(shaped(9'h007, 0, 1, 0)), 'h87);
    wr_ctl(8'hC3);
    load(9'h007); expect_rx(shaped(9'h007, 0, 1, 1), "R7");
    idle(FRM);
    wr_ctl(8'hD3);
    load(9'h0FF); expect_rx(shaped(9'h0FF, 1, 1, 1), "R7");
    idle(FRM);

    // R2 pin ignored in loopback
    wr_ctl(8'hC0);
    seen0 = rx_seen;
    drive_rx(9'h011, 0, 1'b1);
    rxd_i = 1'b0; idle(2000); rxd_i = 1'b1;
    idle(BIT);
    chk(rx_seen == seen0, "R2", "rx count in loopback", rx_seen, seen0);

    // R11 external receive, 8-bit
    wr_ctl(8'h40);
    idle(10);
    expect_rx(9'h06D, "R11");
    drive_rx(9'h06D, 0, 1'b1);
    idle(BIT);

    // R10 short glitch discarded
    seen0 = rx_seen;
    @(negedge clk_i);
    rxd_i = 1'b0; idle(3 * DIV); rxd_i = 1'b1;
    idle(FRM);
    chk(rx_seen == seen0, "R10", "rx count after glitch", rx_seen, seen0);

    // R11 bad stop bit drops the character
    seen0 = rx_seen;
    drive_rx(9'h0C4, 0, 1'b0);
    idle(FRM);
    chk(rx_seen == seen0, "R11", "rx count after bad stop", rx_seen, seen0);

    // R6 external nine-bit receive
    wr_ctl(8'h50);
    idle(10);
    expect_rx(9'h155, "R6");
    drive_rx(9'h155, 1, 1'b1);
    idle(BIT);

    // R3 disable mid-frame, then load while disabled
    wr_ctl(8'hC0);
    load(9'h0F0);
    idle(200);
    wr_ctl(8'h00);
    chk(tx_empty_o && tx_done_o, "R3", "flags forced", int'({tx_empty_o, tx_done_o}), 3);
    chk(!tx_irq_o && txd_o, "R3", "irq/txd", int'({tx_irq_o, txd_o}), 1);
    load(9'h012);
    wr_ctl(8'h40);
    idle(FRM);
    chk(tx_empty_o && tx_done_o, "R3", "load while disabled ignored", int'({tx_empty_o, tx_done_o}), 3);

    idle(20);
    chk(rx_exp_q.size() == 0, "R11", "characters still expected", rx_exp_q.size(), 0);
    finish_run();
  end

endmodule